// File: doc/BRIEF.md
# Interrupt Status and Card-Presence Unit

This block keeps the interrupt state of a storage-card host controller. Single-cycle event pulses from the command, data and transfer engines set bits in a 32-bit raw status register. Software reads that register directly, or through a masked view that shows only the enabled bits. It clears bits by writing ones to either view. A mask register and an enable bit in a control register together decide whether the single level-sensitive interrupt line is driven high.

A second, narrower status register collects completion flags from the descriptor-based transfer engine. It has its own clear rule: only its low ten bits respond to write-one-to-clear. A level card-detect input is sampled every cycle. Each change of that input records an insertion or a removal in the raw status, and the change also sets or clears a card-present flag in a status register.

All registers sit behind one word-addressed read/write port. The read data is a combinational function of the address. A write takes effect at the next rising clock edge.

Top module: `card_irq_unit`

## Requirements
- R1: Register word addresses are 0 control, 1 mask, 2 masked status, 3 raw status, 4 card status, 5 transfer status. Any other address reads as 0.
- R2: Event input bits set raw status bits at the next clock edge, with this mapping: evt_i[0] to bit 1 (no response), evt_i[1] to bit 2 (command done), evt_i[2] to bit 3 (data done), evt_i[3] to bit 14 (auto-stop done) and evt_i[4] to bit 16 (card-side interrupt).
- R3: The masked status address reads raw AND mask. A write to the mask register leaves the raw bits unchanged.
- R4: A write to address 3 or to address 2 clears every raw bit whose write-data bit is 1. Raw bits written as 0 keep their value.
- R5: irq_o is high exactly when control bit 4 is set and raw AND mask is nonzero. Otherwise irq_o is low.
- R6: A write to the control register stores the write data with bits 2:0 forced to 0.
- R7: A rising card_det_i sets raw bit 30, clears raw bit 31 and sets card status bit 8. A falling card_det_i sets raw bit 31, clears raw bit 30 and clears card status bit 8. Each takes effect one edge after the input changes.
- R8: In the transfer status register, dma_tx_done_i sets bits 0 and 8, and dma_rx_done_i sets bits 1 and 8. A write clears the bits that are 1 in write data 9:0. Bits 31:10 read 0 and no write changes them.
- R9: When an event sets a bit in the same cycle that a write clears it, the bit ends up set. This holds for raw status, including card events, and for transfer status.
- R10: After reset, control, mask, raw status and transfer status read 0, card status reads 0x100 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| evt_i | input | 5 | Raw-status event pulses |
| dma_tx_done_i | input | 1 | Transfer engine finished a transmit |
| dma_rx_done_i | input | 1 | Transfer engine finished a receive |
| card_det_i | input | 1 | Card-detect level, 1 when a card is present |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is a set and a clear landing on the same bit in the same cycle. It matters most for the card bits, because those are set by an edge on a level input rather than by a pulse. The bench reaches it by driving the card-detect change, or the event pulse, in the same half-cycle as the clearing write. It then reads the bit back and expects it to be set. The transfer-status rule that upper bits ignore writes is observed by writing ones above bit 9 and confirming that the lower flags and the zero upper field read back unchanged.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_EVT   = 5;
    localparam int DMA_CLR_W = 10;

    // word addresses
    localparam int OFS_CTRL   = 0;
    localparam int OFS_MASK   = 1;
    localparam int OFS_MASKED = 2;
    localparam int OFS_RAW    = 3;
    localparam int OFS_STATUS = 4;
    localparam int OFS_DMA    = 5;

    // bit positions
    localparam int RAW_REMOVED    = 31;
    localparam int RAW_INSERTED   = 30;
    localparam int STAT_PRESENT   = 8;
    localparam int CTRL_IRQ_EN    = 4;
    localparam int CTRL_SELFCLR_W = 3;
    localparam int DMA_TX         = 0;
    localparam int DMA_RX         = 1;
    localparam int DMA_SUM        = 8;

    typedef struct packed {
        logic [DATA_W-1:0]    ctrl;
        logic [DATA_W-1:0]    mask;
        logic [DATA_W-1:0]    raw;
        logic [DMA_CLR_W-1:0] dma;
    } irq_state_t;

    // raw-status bit driven by each event input
    function automatic int evt_bit(input int idx);
        case (idx)
            0:       return 1;
            1:       return 2;
            2:       return 3;
            3:       return 14;
            4:       return 16;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/card_irq_evt_map.sv
module card_irq_evt_map
    import card_irq_pkg::*;
#(
    parameter int N_EVT = NUM_EVT,
    parameter int W     = DATA_W
) (
    input  logic [N_EVT-1:0] evt_i,
    output logic [W-1:0]     set_o
);

    logic [W-1:0] one_hot [N_EVT];

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        assign one_hot[g] = evt_i[g] ? (W'(1) << evt_bit(g)) : '0;
    end

    always_comb begin
        set_o = '0;
        for (int e = 0; e < N_EVT; e++) begin
            set_o = set_o | one_hot[e];
        end
    end

endmodule

// File: rtl/card_irq_card_det.sv
module card_irq_card_det (
    input  logic clk,
    input  logic rst_n,
    input  logic card_det_i,
    output logic insert_o,
    output logic remove_o,
    output logic present_o
);

    logic present_d, present_q;

    always_comb begin
        present_d = card_det_i;
        insert_o  = card_det_i & ~present_q;
        remove_o  = ~card_det_i & present_q;
        present_o = present_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) present_q <= 1'b1;
        else        present_q <= present_d;
    end

endmodule

// File: rtl/card_irq_unit.sv
module card_irq_unit
    import card_irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              dma_tx_done_i,
    input  logic              dma_rx_done_i,
    input  logic              card_det_i,
    output logic              irq_o
);

    localparam logic [DATA_W-1:0] CTRL_KEEP = ~DATA_W'((1 << CTRL_SELFCLR_W) - 1);

    irq_state_t st_d, st_q;

    logic [DATA_W-1:0] evt_set;
    logic              card_ins, card_rem, card_present;

    card_irq_evt_map #(.N_EVT(NUM_EVT), .W(DATA_W)) i_evt_map (
        .evt_i (evt_i),
        .set_o (evt_set)
    );

    card_irq_card_det i_card_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .card_det_i (card_det_i),
        .insert_o   (card_ins),
        .remove_o   (card_rem),
        .present_o  (card_present)
    );

    logic hit_ctrl, hit_mask, hit_clr, hit_dma;
    logic [DATA_W-1:0]    raw_clr;
    logic [DMA_CLR_W-1:0] dma_clr, dma_set;

    always_comb begin
        hit_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
        hit_mask = reg_wr && (reg_addr == ADDR_W'(OFS_MASK));
        hit_clr  = reg_wr && ((reg_addr == ADDR_W'(OFS_RAW)) ||
                              (reg_addr == ADDR_W'(OFS_MASKED)));
        hit_dma  = reg_wr && (reg_addr == ADDR_W'(OFS_DMA));

        raw_clr = hit_clr ? reg_wdata : '0;
        dma_clr = hit_dma ? reg_wdata[DMA_CLR_W-1:0] : '0;

        dma_set          = '0;
        dma_set[DMA_TX]  = dma_tx_done_i;
        dma_set[DMA_RX]  = dma_rx_done_i;
        dma_set[DMA_SUM] = dma_tx_done_i | dma_rx_done_i;

        st_d = st_q;
        if (hit_ctrl) st_d.ctrl = reg_wdata & CTRL_KEEP;
        if (hit_mask) st_d.mask = reg_wdata;

        // clear first, then set: a same-cycle event wins
        st_d.raw = (st_q.raw & ~raw_clr) | evt_set;
        if (card_ins) begin
            st_d.raw[RAW_INSERTED] = 1'b1;
            st_d.raw[RAW_REMOVED]  = 1'b0;
        end
        if (card_rem) begin
            st_d.raw[RAW_REMOVED]  = 1'b1;
            st_d.raw[RAW_INSERTED] = 1'b0;
        end

        st_d.dma = (st_q.dma & ~dma_clr) | dma_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(OFS_CTRL):   reg_rdata = st_q.ctrl;
            ADDR_W'(OFS_MASK):   reg_rdata = st_q.mask;
            ADDR_W'(OFS_MASKED): reg_rdata = st_q.raw & st_q.mask;
            ADDR_W'(OFS_RAW):    reg_rdata = st_q.raw;
            ADDR_W'(OFS_STATUS): reg_rdata = DATA_W'(card_present) << STAT_PRESENT;
            ADDR_W'(OFS_DMA):    reg_rdata = DATA_W'(st_q.dma);
            default:             reg_rdata = '0;
        endcase
    end

    assign irq_o = st_q.ctrl[CTRL_IRQ_EN] && ((st_q.raw & st_q.mask) != '0);

endmodule

// File: rtl/card_irq_unit_chk.sv
module card_irq_unit_chk
    import card_irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [NUM_EVT-1:0]   evt_i,
    input logic                 dma_tx_done_i,
    input logic                 card_det_i,
    input logic                 irq_o,
    input logic [DATA_W-1:0]    raw_q,
    input logic [DATA_W-1:0]    ctrl_q,
    input logic [DMA_CLR_W-1:0] dma_q,
    input logic                 present_q
);

    logic clr_wr;
    assign clr_wr = reg_wr && ((reg_addr == ADDR_W'(OFS_RAW)) ||
                               (reg_addr == ADDR_W'(OFS_MASKED)));

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[1] |=> raw_q[2]);

    assert_w1c_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && reg_wdata[2] && !evt_i[1]) |=> !raw_q[2]);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && reg_wdata[3] && evt_i[2]) |=> raw_q[3]);

    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTRL_IRQ_EN] |-> !irq_o);

    assert_ctrl_selfclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_CTRL)) |=> (ctrl_q[CTRL_SELFCLR_W-1:0] == '0));

    assert_card_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_q[RAW_REMOVED] && raw_q[RAW_INSERTED]));

    assert_card_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (card_det_i != present_q) |=> (present_q == $past(card_det_i)));

    assert_dma_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_DMA) && reg_wdata[DMA_TX] && !dma_tx_done_i)
        |=> !dma_q[DMA_TX]);

endmodule

bind card_irq_unit card_irq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .evt_i         (evt_i),
    .dma_tx_done_i (dma_tx_done_i),
    .card_det_i    (card_det_i),
    .irq_o         (irq_o),
    .raw_q         (st_q.raw),
    .ctrl_q        (st_q.ctrl),
    .dma_q         (st_q.dma),
    .present_q     (card_present)
);

// File: tb/test_card_irq_unit.sv
module test_card_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  evt_i = '0;
    logic        dma_tx_done_i = 1'b0;
    logic        dma_rx_done_i = 1'b0;
    logic        card_det_i = 1'b1;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_irq_unit #(.ADDR_W(AW)) i_card_irq_unit (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .evt_i (evt_i),
        .dma_tx_done_i (dma_tx_done_i), .dma_rx_done_i (dma_rx_done_i),
        .card_det_i (card_det_i), .irq_o (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic rd_chk(input string req, input int addr, input logic [31:0] exp);
        reg_addr = AW'(addr);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset;
        rd_chk("R10 ctrl", 0, 32'h0);
        rd_chk("R10 mask", 1, 32'h0);
        rd_chk("R10 raw", 3, 32'h0);
        rd_chk("R10 status", 4, 32'h100);
        rd_chk("R10 dma", 5, 32'h0);
        chk("R10 irq", {31'h0, irq_o}, 32'h0);
        rd_chk("R1 unmapped", 7, 32'h0);
    endtask

    task automatic t_events;
        pulse(5'b11111);
        rd_chk("R2 all events", 3, 32'h0001_400E);
        wr(1, 32'h0000_4006);
        rd_chk("R3 masked", 2, 32'h0000_4006);
        rd_chk("R3 raw unchanged by mask", 3, 32'h0001_400E);
        rd_chk("R1 mask readback", 1, 32'h0000_4006);
    endtask

    task automatic t_w1c;
        wr(3, 32'h4);
        rd_chk("R4 clear via raw", 3, 32'h0001_400A);
        wr(2, 32'h0001_0000);
        rd_chk("R4 clear via masked", 3, 32'h0000_400A);
        wr(3, 32'hFFFF_FFFF);
        rd_chk("R4 clear all", 3, 32'h0);
    endtask

    task automatic t_irq;
        pulse(5'b00010);
        wr(0, 32'h0);
        chk("R5 gated off", {31'h0, irq_o}, 32'h0);
        wr(0, 32'h10);
        chk("R5 enabled", {31'h0, irq_o}, 32'h1);
        wr(1, 32'h0);
        chk("R5 masked off", {31'h0, irq_o}, 32'h0);
        wr(1, 32'h4);
        chk("R5 unmasked", {31'h0, irq_o}, 32'h1);
        wr(3, 32'h4);
        chk("R5 cleared", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_ctrl;
        wr(0, 32'h17);
        rd_chk("R6 selfclear", 0, 32'h10);
        wr(0, 32'hFFFF_FFFF);
        rd_chk("R6 all ones", 0, 32'hFFFF_FFF8);
    endtask

    task automatic t_card;
        @(negedge clk); card_det_i = 1'b0;
        @(negedge clk);
        rd_chk("R7 removed raw", 3, 32'h8000_0000);
        rd_chk("R7 removed status", 4, 32'h0);
        @(negedge clk); card_det_i = 1'b1;
        @(negedge clk);
        rd_chk("R7 inserted raw", 3, 32'h4000_0000);
        rd_chk("R7 inserted status", 4, 32'h100);
        wr(3, 32'h4000_0000);
        rd_chk("R7 cleared stays", 3, 32'h0);
    endtask

    task automatic t_dma;
        @(negedge clk); dma_tx_done_i = 1'b1;
        @(negedge clk); dma_tx_done_i = 1'b0;
        rd_chk("R8 tx", 5, 32'h101);
        @(negedge clk); dma_rx_done_i = 1'b1;
        @(negedge clk); dma_rx_done_i = 1'b0;
        rd_chk("R8 rx", 5, 32'h103);
        wr(5, 32'h1);
        rd_chk("R8 clear bit0", 5, 32'h102);
        wr(5, 32'hFFFF_FC00);
        rd_chk("R8 upper write ignored", 5, 32'h102);
        wr(5, 32'h3FF);
        rd_chk("R8 clear all", 5, 32'h0);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        evt_i = 5'b00010; reg_wr = 1'b1; reg_addr = AW'(3); reg_wdata = 32'h4;
        @(negedge clk);
        evt_i = '0; reg_wr = 1'b0;
        rd_chk("R9 event beats clear", 3, 32'h4);
        wr(3, 32'hFFFF_FFFF);
        @(negedge clk);
        card_det_i = 1'b0; reg_wr = 1'b1; reg_addr = AW'(2); reg_wdata = 32'h8000_0000;
        @(negedge clk);
        reg_wr = 1'b0;
        rd_chk("R9 card beats clear", 3, 32'h8000_0000);
        @(negedge clk);
        dma_tx_done_i = 1'b1; reg_wr = 1'b1; reg_addr = AW'(5); reg_wdata = 32'h101;
        @(negedge clk);
        dma_tx_done_i = 1'b0; reg_wr = 1'b0;
        rd_chk("R9 dma beats clear", 5, 32'h101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_w1c();
        t_irq();
        t_ctrl();
        t_card();
        t_dma();
        t_set_wins();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule